// File: doc/BRIEF.md
# Audio Control Register Interface

This block is a two-wire serial slave that holds the control settings of an audio processor. A host addresses it with a fixed 7-bit device address. The host then sends a subaddress byte that picks one of nine configuration registers and says whether the index should step forward after each byte. The data bytes that follow are written into the chosen registers. All nine registers are driven out as parallel 8-bit buses, which the audio path consumes directly.

When the host addresses the block for reading, the block returns a status byte that carries two live mute flags. The block samples those flags again at every acknowledge from the host, so the host can poll them for as long as it likes without sending the address again. The clock and data lines are sampled by a much faster system clock. The data line is driven open-drain through a single pull-low enable.

Top module: `audio_ctrl_i2c_regs`

## Requirements
- R1: After reset, all nine registers read 0xFE and `sda_oe` is 0.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. An address byte whose upper seven bits are 1000100 is acknowledged: `sda_oe` is 1 during the ninth clock and 0 again by the first bit of the next byte. Any other address gets no acknowledge, and the block ignores the rest of that transfer.
- R3: In the subaddress byte, bits 3:0 give the register index and bit 4 enables auto-increment. Bits 7:5 have no effect. The subaddress byte is acknowledged.
- R4: With auto-increment off, each data byte is acknowledged and overwrites the same register.
- R5: With auto-increment on, the index steps by one after each data byte, and index 8 is followed by index 0.
- R6: A data byte sent to an index of 9 to 15 is acknowledged but changes no register. With auto-increment on, such an index does not move.
- R7: Index 0 drives `src_sel`, 1 `loud_att`, 2 `vol_ctl`, 3 `tone_ctl`, 4 `spk_lf_att`, 5 `spk_lr_att`, 6 `spk_rf_att`, 7 `spk_rr_att` and 8 `mute_ctl`.
- R8: The read byte is sent MSB first. Bit 2 is `soft_mute_st`, bit 1 is `zc_mute_st`, and bits 7:3 and bit 0 read as 1. The block changes `sda_oe` only while SCL is low.
- R9: The status byte is sampled when the address is acknowledged and again at each host acknowledge. A host non-acknowledge ends the read, and the block stops driving SDA.
- R10: A stop or a new start in the middle of a data byte discards that byte. After a repeated start, a new address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| soft_mute_st | input | 1 | Soft mute active flag |
| zc_mute_st | input | 1 | Zero-crossing muted flag |
| src_sel | output | 8 | Register 0, input selection and gain |
| loud_att | output | 8 | Register 1, loudness |
| vol_ctl | output | 8 | Register 2, volume |
| tone_ctl | output | 8 | Register 3, bass and treble |
| spk_lf_att | output | 8 | Register 4, left front attenuator |
| spk_lr_att | output | 8 | Register 5, left rear attenuator |
| spk_rf_att | output | 8 | Register 6, right front attenuator |
| spk_rr_att | output | 8 | Register 7, right rear attenuator |
| mute_ctl | output | 8 | Register 8, mute control |

## Verification
Every SCL edge passes through two synchroniser flops and one edge flop before the state machine sees it. As a result, a register write, an acknowledge and a transmitted data bit all appear about four system cycles after the SCL falling edge that triggers them. The bench holds each SCL phase for five or ten cycles. It samples SDA five cycles into the SCL high phase, by which time the value the block drives has long settled. Register outputs are compared against the bench model only after the stop condition plus idle time, so every write has landed.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int DW       = 8;
  localparam int NREG     = 9;
  localparam int IDXW     = 4;
  localparam int AW       = 7;
  localparam logic [DW-1:0] RST_VAL  = 8'hFE;
  localparam logic [AW-1:0] DEV_ADDR = 7'b1000100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_SUB, PH_DATA
  } phase_t;
endpackage

// File: rtl/acr_line_sync.sv
module acr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], line_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/acr_reg_bank.sv
module acr_reg_bank #(
  parameter int DW   = 8,
  parameter int NREG = 9,
  parameter int IDXW = 4,
  parameter logic [DW-1:0] RST_VAL = 8'hFE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDXW-1:0]      widx,
  input  logic [DW-1:0]        wdata,
  output logic [NREG*DW-1:0]   regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] q;
    assign en = we && (widx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (en) q <= wdata;
    end
    assign regs_flat[g*DW +: DW] = q;
  end
endmodule

// File: rtl/acr_bus_fsm.sv
module acr_bus_fsm
  import acr_pkg::*;
#(
  parameter logic [AW-1:0] ADDR = DEV_ADDR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_lvl,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            soft_mute,
  input  logic            zc_mute,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NREG - 1);
  localparam logic [3:0]      BITS = 4'(DW);

  state_t          st_q, st_d;
  phase_t          ph_q, ph_d;
  logic [3:0]      bitc_q, bitc_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            ainc_q, ainc_d;
  logic            rw_q, rw_d;
  logic            mack_q, mack_d;
  logic            oe_q, oe_d;
  logic            we_q, we_d;
  logic [IDXW-1:0] widx_q, widx_d;
  logic [DW-1:0]   wdat_q, wdat_d;
  logic [DW-1:0]   status;

  assign status = {5'b11111, soft_mute, zc_mute, 1'b1};

  always_comb begin
    st_d   = st_q;   ph_d   = ph_q;   bitc_d = bitc_q; sh_d = sh_q;
    idx_d  = idx_q;  ainc_d = ainc_q; rw_d   = rw_q;   mack_d = mack_q;
    oe_d   = oe_q;   we_d   = 1'b0;   widx_d = widx_q; wdat_d = wdat_q;
    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d   = ST_RX;
      ph_d   = PH_ADDR;
      bitc_d = '0;
      oe_d   = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && bitc_q < BITS) begin
            sh_d   = {sh_q[DW-2:0], sda_lvl};
            bitc_d = bitc_q + 4'd1;
          end else if (scl_fall && bitc_q == BITS) begin
            case (ph_q)
              PH_ADDR: begin
                if (sh_q[DW-1:1] == ADDR) begin
                  rw_d = sh_q[0];
                  st_d = ST_RX_ACK;
                  oe_d = 1'b1;
                end else begin
                  st_d = ST_SKIP;
                end
              end
              PH_SUB: begin
                idx_d  = sh_q[IDXW-1:0];
                ainc_d = sh_q[4];
                st_d   = ST_RX_ACK;
                oe_d   = 1'b1;
              end
              default: begin
                if (idx_q <= LAST) begin
                  we_d   = 1'b1;
                  widx_d = idx_q;
                  wdat_d = sh_q;
                end
                if (ainc_q) begin
                  if (idx_q == LAST)     idx_d = '0;
                  else if (idx_q < LAST) idx_d = idx_q + 1'b1;
                end
                st_d = ST_RX_ACK;
                oe_d = 1'b1;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bitc_d = '0;
            oe_d   = 1'b0;
            st_d   = ST_RX;
            if (ph_q == PH_ADDR && rw_q) begin
              st_d = ST_TX;
              sh_d = status;
              oe_d = ~status[DW-1];
            end else if (ph_q == PH_ADDR) begin
              ph_d = PH_SUB;
            end else begin
              ph_d = PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitc_q == BITS - 4'd1) begin
              st_d   = ST_TX_ACK;
              oe_d   = 1'b0;
              bitc_d = '0;
            end else begin
              sh_d   = {sh_q[DW-2:0], 1'b1};
              oe_d   = ~sh_q[DW-2];
              bitc_d = bitc_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              st_d   = ST_TX;
              sh_d   = status;
              oe_d   = ~status[DW-1];
              bitc_d = '0;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= PH_ADDR; bitc_q <= '0; sh_q <= '0;
      idx_q <= '0; ainc_q <= 1'b0; rw_q <= 1'b0; mack_q <= 1'b0;
      oe_q <= 1'b0; we_q <= 1'b0; widx_q <= '0; wdat_q <= '0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bitc_q <= bitc_d; sh_q <= sh_d;
      idx_q <= idx_d; ainc_q <= ainc_d; rw_q <= rw_d; mack_q <= mack_d;
      oe_q <= oe_d; we_q <= we_d; widx_q <= widx_d; wdat_q <= wdat_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = we_q;
  assign wr_idx  = widx_q;
  assign wr_data = wdat_q;
endmodule

// File: rtl/audio_ctrl_i2c_regs.sv
module audio_ctrl_i2c_regs
  import acr_pkg::*;
#(
  parameter logic [AW-1:0] ADDR = DEV_ADDR,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       soft_mute_st,
  input  logic       zc_mute_st,
  output logic [7:0] src_sel,
  output logic [7:0] loud_att,
  output logic [7:0] vol_ctl,
  output logic [7:0] tone_ctl,
  output logic [7:0] spk_lf_att,
  output logic [7:0] spk_lr_att,
  output logic [7:0] spk_rf_att,
  output logic [7:0] spk_rr_att,
  output logic [7:0] mute_ctl
);
  logic [1:0]         rst_sh;
  logic               rst_int_n;
  logic               scl_lvl, scl_rise, scl_fall;
  logic               sda_lvl, sda_rise, sda_fall;
  logic               start_det, stop_det;
  logic               wr_en;
  logic [IDXW-1:0]    wr_idx;
  logic [DW-1:0]      wr_data;
  logic [NREG*DW-1:0] regs_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_int_n = rst_sh[1];

  acr_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_int_n), .line_in(scl_in),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  acr_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_int_n), .line_in(sda_in),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  acr_bus_fsm #(.ADDR(ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det),
    .soft_mute(soft_mute_st), .zc_mute(zc_mute_st),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  acr_reg_bank #(.DW(DW), .NREG(NREG), .IDXW(IDXW), .RST_VAL(RST_VAL)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .we(wr_en), .widx(wr_idx),
    .wdata(wr_data), .regs_flat(regs_flat));

  assign src_sel    = regs_flat[0*DW +: DW];
  assign loud_att   = regs_flat[1*DW +: DW];
  assign vol_ctl    = regs_flat[2*DW +: DW];
  assign tone_ctl   = regs_flat[3*DW +: DW];
  assign spk_lf_att = regs_flat[4*DW +: DW];
  assign spk_lr_att = regs_flat[5*DW +: DW];
  assign spk_rf_att = regs_flat[6*DW +: DW];
  assign spk_rr_att = regs_flat[7*DW +: DW];
  assign mute_ctl   = regs_flat[8*DW +: DW];
endmodule

// File: rtl/acr_checker.sv
module acr_checker #(
  parameter int DW   = 8,
  parameter int NREG = 9,
  parameter int IDXW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_lvl,
  input logic               sda_oe,
  input logic               stop_det,
  input logic               wr_en,
  input logic [IDXW-1:0]    wr_idx,
  input logic [NREG*DW-1:0] regs_flat
);
  // R8: the slave's drive on SDA moves only while SCL is low
  a_r8_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R10: a stop condition leaves SDA released
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R6: no write strobe reaches an index outside the bank
  a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDXW'(NREG)));

  // R4: registers hold whenever no write strobe is issued
  a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

bind audio_ctrl_i2c_regs acr_checker #(
  .DW(acr_pkg::DW), .NREG(acr_pkg::NREG), .IDXW(acr_pkg::IDXW)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
  .stop_det(stop_det), .wr_en(wr_en), .wr_idx(wr_idx), .regs_flat(regs_flat)
);

// File: tb/tb_audio_ctrl_i2c_regs.sv
module tb_audio_ctrl_i2c_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic soft_st = 1'b0, zc_st = 1'b0;
  logic sda_oe, sda_line;
  logic [7:0] r_src, r_loud, r_vol, r_tone, r_lf, r_lr, r_rf, r_rr, r_mute;
  int checks = 0, errors = 0;
  logic [7:0] expv [9];
  logic [7:0] dbuf [16];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  audio_ctrl_i2c_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .soft_mute_st(soft_st), .zc_mute_st(zc_st),
    .src_sel(r_src), .loud_att(r_loud), .vol_ctl(r_vol), .tone_ctl(r_tone),
    .spk_lf_att(r_lf), .spk_lr_att(r_lr), .spk_rf_att(r_rf), .spk_rr_att(r_rr),
    .mute_ctl(r_mute));

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] port_reg(input int i);
    case (i)
      0: return r_src;   1: return r_loud;  2: return r_vol;
      3: return r_tone;  4: return r_lf;    5: return r_lr;
      6: return r_rf;    7: return r_rr;    default: return r_mute;
    endcase
  endfunction

  function automatic logic [3:0] bump(input logic [3:0] i);
    if (i == 4'd8) return 4'd0;
    if (i < 4'd8)  return i + 4'd1;
    return i;
  endfunction

  function automatic logic [7:0] stat_byte(input logic s, input logic z);
    return {5'b11111, s, z, 1'b1};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; w(5); scl_m = 1'b1; w(10); sda_m = 1'b0; w(10); scl_m = 1'b0; w(5);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(5); scl_m = 1'b1; w(10); sda_m = 1'b1; w(10);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; w(5); scl_m = 1'b1; w(10); scl_m = 1'b0; w(5);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; w(5); scl_m = 1'b1; w(5); b = sda_line; w(5); scl_m = 1'b0; w(5);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
  endtask

  // writes n bytes from dbuf after subaddress sub, updating the model
  task automatic wr_txn(input string req, input logic [7:0] sub, input int n);
    logic a;
    logic [3:0] idx;
    i2c_start();
    send_byte(8'h88, a); check({req, " address ack"}, {7'd0, a}, 8'd1);
    send_byte(sub, a);   check({req, " subaddress ack"}, {7'd0, a}, 8'd1);
    idx = sub[3:0];
    for (int k = 0; k < n; k++) begin
      send_byte(dbuf[k], a);
      check({req, " data ack"}, {7'd0, a}, 8'd1);
      if (idx < 4'd9) expv[idx] = dbuf[k];
      if (sub[4]) idx = bump(idx);
    end
    i2c_stop();
    w(20);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 9; i++) check($sformatf("%s reg%0d", req, i), port_reg(i), expv[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rb;
    void'($urandom(32'd4711));
    for (int i = 0; i < 9; i++) expv[i] = 8'hFE;
    w(5); rst_n = 1'b1; w(10);

    // R1: reset state
    check_regs("R1");
    check("R1 sda_oe", {7'd0, sda_oe}, 8'd0);

    // R2: wrong address is not acknowledged and the transfer is ignored
    i2c_start();
    send_byte(8'h8A, a); check("R2 wrong address nack", {7'd0, a}, 8'd0);
    send_byte(8'h00, a); check("R2 ignored subaddress nack", {7'd0, a}, 8'd0);
    send_byte(8'h11, a);
    i2c_stop(); w(20);
    check_regs("R2 ignored");

    // R2: acknowledge released by the next byte's first bit
    i2c_start();
    send_byte(8'h88, a);
    sda_m = 1'b1; w(5);
    check("R2 ack released", {7'd0, sda_oe}, 8'd0);
    scl_m = 1'b1; w(10); scl_m = 1'b0; w(5);
    i2c_stop(); w(20);

    // R4: no auto-increment rewrites one register
    dbuf[0] = 8'h12; dbuf[1] = 8'h34; dbuf[2] = 8'h56;
    wr_txn("R4", 8'h00, 3);
    check_regs("R4");

    // R3: bits 7:5 of the subaddress have no effect
    dbuf[0] = 8'h55;
    wr_txn("R3", 8'hE2, 1);
    check_regs("R3");

    // R5: auto-increment from 6 wraps 8 -> 0
    dbuf[0] = 8'hA6; dbuf[1] = 8'hA7; dbuf[2] = 8'hA8; dbuf[3] = 8'hA0; dbuf[4] = 8'hA1;
    wr_txn("R5", 8'h16, 5);
    check_regs("R5");
    check("R5 wrap to src_sel", r_src, 8'hA0);

    // R7: full sweep with random data, each index mapped to its port
    for (int rep = 0; rep < 3; rep++) begin
      for (int k = 0; k < 9; k++) dbuf[k] = 8'($urandom);
      wr_txn("R7", 8'h10, 9);
      check_regs("R7");
    end

    // random constrained writes
    for (int rep = 0; rep < 8; rep++) begin
      logic [7:0] sub;
      int n;
      sub = {3'($urandom), 1'($urandom), 4'($urandom_range(0, 8))};
      n = $urandom_range(1, 6);
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
      wr_txn("R5 random", sub, n);
      check_regs("R4 R5 random");
    end

    // R6: out-of-range index acknowledged, nothing written
    dbuf[0] = 8'h01; dbuf[1] = 8'h02; dbuf[2] = 8'h03;
    wr_txn("R6", 8'h0B, 2);
    check_regs("R6 no autoinc");
    wr_txn("R6", 8'h1F, 3);
    check_regs("R6 autoinc");

    // R10: stop in the middle of a data byte discards it
    i2c_start();
    send_byte(8'h88, a); send_byte(8'h03, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop(); w(20);
    check("R10 partial byte dropped", r_tone, expv[3]);

    // R10: repeated start mid-byte, then a new transfer
    i2c_start();
    send_byte(8'h88, a); send_byte(8'h03, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    i2c_start();
    send_byte(8'h88, a); check("R10 repeated start ack", {7'd0, a}, 8'd1);
    send_byte(8'h01, a);
    send_byte(8'h5A, a);
    i2c_stop(); w(20);
    expv[1] = 8'h5A;
    check("R10 tone kept", r_tone, expv[3]);
    check("R10 write after repeated start", r_loud, 8'h5A);

    // R8 R9: read status with refresh at each host ack
    soft_st = 1'b1; zc_st = 1'b0;
    i2c_start();
    send_byte(8'h89, a); check("R8 read address ack", {7'd0, a}, 8'd1);
    recv_byte(rb); check("R8 first status", rb, stat_byte(1'b1, 1'b0));
    for (int rep = 0; rep < 6; rep++) begin
      logic s, z;
      s = 1'($urandom); z = 1'($urandom);
      soft_st = s; zc_st = z;
      send_bit(1'b0);
      recv_byte(rb); check("R9 refreshed status", rb, stat_byte(s, z));
    end
    soft_st = 1'b0; zc_st = 1'b1;
    send_bit(1'b0);
    recv_byte(rb); check("R8 zc only", rb, stat_byte(1'b0, 1'b1));
    send_bit(1'b1);
    for (int i = 0; i < 4; i++) begin
      recv_bit(a);
      check("R9 released after nack", {7'd0, sda_oe}, 8'd0);
    end
    i2c_stop(); w(20);
    check_regs("R9 read leaves registers");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule